// File: doc/BRIEF.md
# Queue Doorbell and Error Interrupt Control

This block keeps the control state of one instruction queue. Software rings the doorbell by writing a count of 64-bit instruction words, and the block adds it to a pending total. The fetch logic takes that total down by one instruction (eight words) at a time. When the total wraps past its width, the block raises an overflow cause.

Five interrupt causes sit in a status register: software error from the engines, result-write response error, instruction-read response error, doorbell overflow and mailbox write. Each cause has its own enable, and the interrupt line is the OR of the enabled causes. Any of the three fault causes stops the queue by clearing its enable bit. This happens whether hardware or a software set raised the cause. The one exception is a queue that has continue-on-error set, which only records the fault.

Software uses a small register port with a one-cycle read latency to ring the doorbell, inspect and clear causes, inject causes, manage the enables and set the queue control bits.

Top module: `qdb_err_ctl`

## Requirements
- R1: After reset the pending count, status bits, cause enables, queue enable, continue-on-error, reg_rdata and irq are all zero.
- R2: A write to address 0 whose value has its low three bits clear adds that value to the pending count, modulo 2^20. A read of address 0 returns the count, and pend_cnt shows it on the cycle after the write edge.
- R3: When a doorbell addition carries out of bit 19, status bit 1 (doorbell overflow) is set, and the count keeps the wrapped sum. Writing 2^20 minus the current count therefore leaves zero and sets bit 1.
- R4: A doorbell write with any of its low three bits set leaves the count unchanged and sets status bit 4 (software error).
- R5: A fetch_dec pulse subtracts 8 from the count when the count is at least 8 and does nothing otherwise. It combines with a doorbell write in the same cycle.
- R6: Address 1 reads the status register. Bits 4..0 are software error, result-write error, instruction-read error, doorbell overflow and mailbox. Writing a one to a bit of address 1 clears that bit, but a cause raised in the same cycle wins over the clear.
- R7: Pulses on ev_sw_err, ev_res_wr_err, ev_ins_rd_err and ev_mbox_wr set status bits 4, 3, 2 and 0.
- R8: Writing a one to a bit of address 2 sets that status bit.
- R9: Writing ones to address 3 sets cause enables, and writing ones to address 4 clears them. Reads of address 3 or 4 return the enables.
- R10: irq equals the OR over bits of status AND enable. It changes on the same edge as the status and enable bits it depends on.
- R11: With continue-on-error clear, any setting of status bit 3, 2 or 1, by any route, clears q_ena on that edge. This takes priority over a control write in that cycle. Bits 4 and 0 never touch q_ena.
- R12: With continue-on-error set, the fault causes are recorded and q_ena keeps its value.
- R13: Address 5 holds queue enable in bit 0 and continue-on-error in bit 1. A write sets both, and a read returns both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 20 | Write data |
| reg_rdata | output | 20 | Read data, valid the cycle after reg_rd |
| ev_sw_err | input | 1 | Engine software error pulse |
| ev_res_wr_err | input | 1 | Result write response error pulse |
| ev_ins_rd_err | input | 1 | Instruction read response error pulse |
| ev_mbox_wr | input | 1 | Mailbox written pulse |
| fetch_dec | input | 1 | Fetch logic consumed one instruction |
| q_ena | output | 1 | Queue enable |
| pend_cnt | output | 20 | Pending doorbell word count |
| irq | output | 1 | Interrupt line |

## Verification
The assertions assume that software keeps the count aligned to whole instructions, which guarantees the count is always a multiple of eight. They also assume that event inputs are single-cycle pulses and that the register strobes are never undefined. The decrement checks hold only in cycles without a doorbell write, and the queue-enable checks hold only in cycles without a control write, so overlapping activity never breaks a property. The stimulus drives each strobe for exactly one cycle and writes misaligned doorbell values only in the test aimed at them. The one deliberate collision, an event together with its clear, falls outside every property's precondition.

// File: rtl/qdb_pkg.sv
package qdb_pkg;
  localparam int unsigned NCAUSE = 5;

  localparam int unsigned C_MBOX = 0;
  localparam int unsigned C_DOVF = 1;
  localparam int unsigned C_IRD  = 2;
  localparam int unsigned C_RWR  = 3;
  localparam int unsigned C_SWE  = 4;

  typedef logic [NCAUSE-1:0] cause_t;

  typedef enum logic [2:0] {
    A_DBELL  = 3'd0,
    A_STAT   = 3'd1,
    A_INJECT = 3'd2,
    A_EN_SET = 3'd3,
    A_EN_CLR = 3'd4,
    A_QCTL   = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/qdb_counter.sv
module qdb_counter #(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned STEP  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_vld,
  input  logic [CNT_W-1:0] add_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             carry
);
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] nxt;
  logic             dec_ok;

  always_comb begin
    sum    = {1'b0, cnt} + (add_vld ? {1'b0, add_val} : '0);
    carry  = sum[CNT_W];
    dec_ok = dec && (cnt >= CNT_W'(STEP));
    nxt    = sum[CNT_W-1:0] - (dec_ok ? CNT_W'(STEP) : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= nxt;
  end
endmodule

// File: rtl/qdb_irq_regs.sv
module qdb_irq_regs
  import qdb_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  cause_t raise,
  input  cause_t clr,
  input  cause_t en_set,
  input  cause_t en_clr,
  output cause_t stat,
  output cause_t en,
  output logic   irq
);
  cause_t stat_n, en_n;

  for (genvar i = 0; i < NCAUSE; i++) begin : g_bit
    always_comb begin
      stat_n[i] = raise[i] | (stat[i] & ~clr[i]);
      en_n[i]   = en_set[i] | (en[i] & ~en_clr[i]);
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        stat[i] <= 1'b0;
        en[i]   <= 1'b0;
      end else begin
        stat[i] <= stat_n[i];
        en[i]   <= en_n[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(stat_n & en_n);
  end
endmodule

// File: rtl/qdb_qena.sv
module qdb_qena (
  input  logic clk,
  input  logic rst,
  input  logic ctl_wr,
  input  logic ena_w,
  input  logic ce_w,
  input  logic fault,
  output logic q_ena,
  output logic cont_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_ena    <= 1'b0;
      cont_err <= 1'b0;
    end else begin
      if (ctl_wr) cont_err <= ce_w;
      if (fault && !cont_err) q_ena <= 1'b0;
      else if (ctl_wr)        q_ena <= ena_w;
    end
  end
endmodule

// File: rtl/qdb_err_ctl.sv
module qdb_err_ctl
  import qdb_pkg::*;
#(
  parameter int unsigned CNT_W      = 20,
  parameter int unsigned INST_WORDS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             ev_sw_err,
  input  logic             ev_res_wr_err,
  input  logic             ev_ins_rd_err,
  input  logic             ev_mbox_wr,
  input  logic             fetch_dec,
  output logic             q_ena,
  output logic [CNT_W-1:0] pend_cnt,
  output logic             irq
);
  localparam int unsigned ALIGN_W = $clog2(INST_WORDS);

  logic   wr_db, wr_stat, wr_inj, wr_ens, wr_enc, wr_ctl;
  logic   db_ok, db_bad, carry, fault, cont_err_q;
  cause_t raise, clr, inj, ens, enc, stat, en;

  always_comb begin
    wr_db   = reg_wr && (reg_addr == A_DBELL);
    wr_stat = reg_wr && (reg_addr == A_STAT);
    wr_inj  = reg_wr && (reg_addr == A_INJECT);
    wr_ens  = reg_wr && (reg_addr == A_EN_SET);
    wr_enc  = reg_wr && (reg_addr == A_EN_CLR);
    wr_ctl  = reg_wr && (reg_addr == A_QCTL);
    db_bad  = wr_db && (reg_wdata[ALIGN_W-1:0] != '0);
    db_ok   = wr_db && !db_bad;
    clr     = wr_stat ? reg_wdata[NCAUSE-1:0] : '0;
    inj     = wr_inj  ? reg_wdata[NCAUSE-1:0] : '0;
    ens     = wr_ens  ? reg_wdata[NCAUSE-1:0] : '0;
    enc     = wr_enc  ? reg_wdata[NCAUSE-1:0] : '0;
    raise          = inj;
    raise[C_SWE]   = inj[C_SWE]  | ev_sw_err | db_bad;
    raise[C_RWR]   = inj[C_RWR]  | ev_res_wr_err;
    raise[C_IRD]   = inj[C_IRD]  | ev_ins_rd_err;
    raise[C_DOVF]  = inj[C_DOVF] | carry;
    raise[C_MBOX]  = inj[C_MBOX] | ev_mbox_wr;
    fault = raise[C_RWR] | raise[C_IRD] | raise[C_DOVF];
  end

  qdb_counter #(.CNT_W(CNT_W), .STEP(INST_WORDS)) u_cnt (
    .clk(clk), .rst(rst), .add_vld(db_ok), .add_val(reg_wdata),
    .dec(fetch_dec), .cnt(pend_cnt), .carry(carry)
  );

  qdb_irq_regs u_irq (
    .clk(clk), .rst(rst), .raise(raise), .clr(clr),
    .en_set(ens), .en_clr(enc), .stat(stat), .en(en), .irq(irq)
  );

  qdb_qena u_qena (
    .clk(clk), .rst(rst), .ctl_wr(wr_ctl), .ena_w(reg_wdata[0]),
    .ce_w(reg_wdata[1]), .fault(fault), .q_ena(q_ena), .cont_err(cont_err_q)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        A_DBELL:            reg_rdata <= pend_cnt;
        A_STAT, A_INJECT:   reg_rdata <= CNT_W'(stat);
        A_EN_SET, A_EN_CLR: reg_rdata <= CNT_W'(en);
        A_QCTL:             reg_rdata <= CNT_W'({cont_err_q, q_ena});
        default:            reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/qdb_err_ctl_chk.sv
module qdb_err_ctl_chk #(
  parameter int unsigned CNT_W   = 20,
  parameter int unsigned ALIGN_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [CNT_W-1:0] reg_wdata,
  input logic             ev_res_wr_err,
  input logic             ev_ins_rd_err,
  input logic             fetch_dec,
  input logic             q_ena,
  input logic             cont_err,
  input logic [CNT_W-1:0] pend_cnt
);
  // R2: count stays instruction-aligned
  a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
    pend_cnt[ALIGN_W-1:0] == '0);

  // R4: misaligned doorbell write leaves count alone
  a_r4_bad_ignored: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd0 && reg_wdata[ALIGN_W-1:0] != '0 && !fetch_dec)
    |=> $stable(pend_cnt));

  // R5: decrement by one instruction
  a_r5_dec: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && fetch_dec && pend_cnt >= CNT_W'(8))
    |=> pend_cnt == $past(pend_cnt) - CNT_W'(8));

  // R5: decrement on an empty count has no effect
  a_r5_empty: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && pend_cnt == '0) |=> pend_cnt == '0);

  // R11: fault with continue-on-error clear stops the queue
  a_r11_stop: assert property (@(posedge clk) disable iff (rst)
    ((ev_res_wr_err || ev_ins_rd_err) && !cont_err) |=> !q_ena);

  // R12: continue-on-error keeps the queue running
  a_r12_keep: assert property (@(posedge clk) disable iff (rst)
    (cont_err && q_ena && !(reg_wr && reg_addr == 3'd5)) |=> q_ena);
endmodule

bind qdb_err_ctl qdb_err_ctl_chk #(.CNT_W(CNT_W), .ALIGN_W(ALIGN_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ev_res_wr_err(ev_res_wr_err),
  .ev_ins_rd_err(ev_ins_rd_err), .fetch_dec(fetch_dec), .q_ena(q_ena),
  .cont_err(cont_err_q), .pend_cnt(pend_cnt)
);

// File: tb/qdb_err_ctl_test.sv
module qdb_err_ctl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [19:0] reg_wdata = '0;
  logic [19:0] reg_rdata;
  logic        ev_sw_err = 1'b0, ev_res_wr_err = 1'b0, ev_ins_rd_err = 1'b0;
  logic        ev_mbox_wr = 1'b0, fetch_dec = 1'b0;
  logic        q_ena, irq;
  logic [19:0] pend_cnt;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  qdb_err_ctl uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_sw_err(ev_sw_err), .ev_res_wr_err(ev_res_wr_err),
    .ev_ins_rd_err(ev_ins_rd_err), .ev_mbox_wr(ev_mbox_wr),
    .fetch_dec(fetch_dec), .q_ena(q_ena), .pend_cnt(pend_cnt), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [19:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [19:0] exp, input string tag);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0;
    chk(tag, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic t_reset;
    chk("R1 pend_cnt", 32'(pend_cnt), 0);
    chk("R1 q_ena", 32'(q_ena), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rdata", 32'(reg_rdata), 0);
    rd(3'd1, 20'h0, "R1 status");
    rd(3'd3, 20'h0, "R1 enables");
    rd(3'd5, 20'h0, "R1 qctl");
  endtask

  task automatic t_doorbell;
    wr(3'd0, 20'd16);
    chk("R2 pend after 16", 32'(pend_cnt), 16);
    wr(3'd0, 20'd8);
    rd(3'd0, 20'd24, "R2 read count");
  endtask

  task automatic t_bad_write;
    wr(3'd0, 20'd5);
    chk("R4 count kept", 32'(pend_cnt), 24);
    rd(3'd1, 20'h10, "R4 swerr set");
    wr(3'd1, 20'h10);
    rd(3'd1, 20'h00, "R6 w1c clears");
  endtask

  task automatic t_fetch;
    @(negedge clk); fetch_dec = 1'b1;
    @(negedge clk); fetch_dec = 1'b0;
    chk("R5 dec by 8", 32'(pend_cnt), 16);
    @(negedge clk); fetch_dec = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 20'd32;
    @(negedge clk); fetch_dec = 1'b0; reg_wr = 1'b0;
    chk("R5 dec with write", 32'(pend_cnt), 40);
    repeat (5) begin
      @(negedge clk); fetch_dec = 1'b1;
    end
    @(negedge clk); fetch_dec = 1'b1;
    @(negedge clk); fetch_dec = 1'b0;
    chk("R5 empty floor", 32'(pend_cnt), 0);
  endtask

  task automatic t_events;
    wr(3'd5, 20'h1);
    @(negedge clk); ev_mbox_wr = 1'b1;
    @(negedge clk); ev_mbox_wr = 1'b0;
    chk("R10 irq masked", 32'(irq), 0);
    chk("R11 mbox keeps q_ena", 32'(q_ena), 1);
    rd(3'd1, 20'h01, "R7 mbox bit");
    wr(3'd3, 20'h01);
    chk("R10 irq enabled", 32'(irq), 1);
    rd(3'd4, 20'h01, "R9 enable read");
    @(negedge clk); ev_sw_err = 1'b1; reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 20'h11;
    @(negedge clk); ev_sw_err = 1'b0; reg_wr = 1'b0;
    chk("R10 irq after clear", 32'(irq), 0);
    chk("R11 swerr keeps q_ena", 32'(q_ena), 1);
    rd(3'd1, 20'h10, "R6 event beats clear");
    @(negedge clk); ev_ins_rd_err = 1'b1;
    @(negedge clk); ev_ins_rd_err = 1'b0;
    chk("R11 rd err stops queue", 32'(q_ena), 0);
    rd(3'd1, 20'h14, "R7 rd err bit");
    wr(3'd5, 20'h1);
    @(negedge clk); ev_res_wr_err = 1'b1;
    @(negedge clk); ev_res_wr_err = 1'b0;
    chk("R11 wr err stops queue", 32'(q_ena), 0);
    wr(3'd1, 20'h1F);
  endtask

  task automatic t_overflow;
    wr(3'd5, 20'h3);
    rd(3'd5, 20'h3, "R13 qctl read");
    wr(3'd0, 20'h80000);
    wr(3'd0, 20'h80000);
    chk("R3 wrapped count", 32'(pend_cnt), 0);
    chk("R12 queue kept", 32'(q_ena), 1);
    rd(3'd1, 20'h02, "R3 overflow bit");
    wr(3'd1, 20'h02);
    wr(3'd0, 20'd24);
    wr(3'd0, 20'hFFFE8);
    chk("R3 reset procedure", 32'(pend_cnt), 0);
    rd(3'd1, 20'h02, "R3 overflow on reset write");
    @(negedge clk); ev_res_wr_err = 1'b1;
    @(negedge clk); ev_res_wr_err = 1'b0;
    chk("R12 wr err recorded only", 32'(q_ena), 1);
    wr(3'd1, 20'h1F);
  endtask

  task automatic t_inject;
    wr(3'd5, 20'h1);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 20'h08;
    @(negedge clk); reg_wr = 1'b0;
    chk("R11 inject stops queue", 32'(q_ena), 0);
    rd(3'd1, 20'h08, "R8 inject sets bit");
    wr(3'd3, 20'h08);
    chk("R10 irq on injected", 32'(irq), 1);
    rd(3'd3, 20'h09, "R9 enables accumulate");
    wr(3'd4, 20'h08);
    chk("R9 enable clear drops irq", 32'(irq), 0);
    rd(3'd3, 20'h01, "R9 enable after clear");
    wr(3'd5, 20'h1);
    wr(3'd2, 20'h10);
    chk("R11 swerr inject keeps q_ena", 32'(q_ena), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_doorbell;
    t_bad_write;
    t_fetch;
    t_events;
    t_overflow;
    t_inject;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1..R13 actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule